// File: doc/BRIEF.md
# Vector Element Selection Unit

This unit builds a packed result vector from a source vector held in a small register array. One start pulse captures the source elements, the selection controls and the lengths. A single sequencer then walks the source or the index list one step per cycle and emits at most one result element per cycle on a write port. The result addresses start at 0 and rise by one with no gaps.

Three selection modes share the sequencer. Strided mode takes every k-th element, starting at the first. Gather mode takes the elements that an index list names, in list order. Compress mode takes the elements whose mask bit is set, in ascending source position. When the last step has been handled, the unit raises a one-cycle completion flag and presents the number of elements written. Index values outside the source are reported and dropped.

Top module: `vsel_unit`

## Requirements
- R1: After reset, `busy_o`, `wr_en_o`, `done_o` and `idx_err_o` are 0 and `res_len_o` is 0.
- R2: With `mode_i`=2'b00 (strided) and stride k, the result holds source positions 1, 1+k, 1+2k, ... up to and including the largest such position not above `src_len_i`. For k=4 the last position is 4*floor((n-1)/4)+1.
- R3: A stride of 0 behaves exactly like a stride of 1.
- R4: With `mode_i`=2'b01 (gather), index entry j sits at `idx_i[j*IDX_W +: IDX_W]`, only entries 0..`idx_cnt_i`-1 are used, and each value v in 1..n selects source position v, written in list order.
- R5: In gather mode, an index value of 0 or above n writes nothing. Instead `idx_err_o` is 1 for one cycle, in the output slot that index would have used.
- R6: With `mode_i`=2'b10 or 2'b11 (compress), mask bit p-1 of `mask_i` selects source position p. Positions are scanned one per cycle in ascending order, and mask bits at or above n are ignored.
- R7: Source position p is element `src_i[(p-1)*ELEM_W +: ELEM_W]`. Written elements appear on consecutive `wr_addr_o` values 0, 1, 2, ..., with at most one write per cycle.
- R8: `res_len_o` equals the number of writes of the job. It is valid from the `done_o` cycle and is held until the next accepted start.
- R9: `done_o` is 1 for exactly one cycle, together with the output of the last step. It comes S cycles after the start-capture edge, where S is ceil(n/k) in strided mode, `idx_cnt_i` in gather mode and n in compress mode, with a minimum of 1.
- R10: A start pulse while `busy_o` is 1 is ignored, and the running job completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures all controls when idle |
| mode_i | input | 2 | 00 strided, 01 gather, 1x compress |
| stride_i | input | IDX_W | Stride for strided mode (0 acts as 1) |
| src_len_i | input | IDX_W | Source length n (clamped to MAX_LEN) |
| src_i | input | MAX_LEN*ELEM_W | Source elements, position 1 in the low bits |
| idx_i | input | MAX_LEN*IDX_W | Index list for gather mode |
| idx_cnt_i | input | IDX_W | Number of index entries used (clamped to MAX_LEN) |
| mask_i | input | MAX_LEN | Selection mask for compress mode |
| busy_o | output | 1 | Job in progress |
| wr_en_o | output | 1 | Result write strobe |
| wr_addr_o | output | PTR_W | Result write address |
| wr_data_o | output | ELEM_W | Result write data |
| idx_err_o | output | 1 | Out-of-range index was skipped |
| done_o | output | 1 | One-cycle completion pulse |
| res_len_o | output | IDX_W | Number of elements written |

## Verification
The assertions assume that reset is asserted before the first edge. They also assume that the controls matter only at an accepted start, so the captured copies stay put while a job runs. The address-step and error-skip properties rely on the unit producing at most one outcome per cycle. The stimulus keeps every length, count and index within the 4-bit fields, and keeps strides up to 9 with lengths up to 8. It drives inputs only on falling edges and holds start for a single cycle, except for the deliberate mid-job pulse that checks that starts are ignored while busy.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    SEL_STRIDE   = 2'b00,
    SEL_GATHER   = 2'b01,
    SEL_COMPRESS = 2'b10
  } sel_mode_e;
endpackage

// File: rtl/vsel_step.sv
module vsel_step
  import vsel_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int IDX_W   = 4,
  parameter int PTR_W   = 3,
  localparam int CUR_W  = IDX_W + 1
) (
  input  sel_mode_e             mode_i,
  input  logic [CUR_W-1:0]      cur_i,
  input  logic [IDX_W-1:0]      len_i,
  input  logic [IDX_W-1:0]      stride_i,
  input  logic [IDX_W-1:0]      cnt_i,
  input  logic [MAX_LEN*IDX_W-1:0] idx_i,
  input  logic [MAX_LEN-1:0]    mask_i,
  output logic                  sel_o,
  output logic                  err_o,
  output logic                  last_o,
  output logic [PTR_W-1:0]      pos_o,
  output logic [CUR_W-1:0]      next_o
);
  logic [PTR_W-1:0] slot;
  logic [IDX_W-1:0] iv;
  logic [CUR_W-1:0] len_x, cnt_x, str_x;
  logic             live, in_rng;

  always_comb begin
    slot   = cur_i[PTR_W-1:0];
    iv     = idx_i[slot*IDX_W +: IDX_W];
    len_x  = {1'b0, len_i};
    cnt_x  = {1'b0, cnt_i};
    str_x  = {1'b0, stride_i};
    live   = 1'b0;
    in_rng = 1'b0;
    sel_o  = 1'b0;
    err_o  = 1'b0;
    pos_o  = slot;
    next_o = cur_i + CUR_W'(1);
    last_o = 1'b1;
    unique case (mode_i)
      SEL_STRIDE: begin
        sel_o  = cur_i < len_x;
        next_o = cur_i + str_x;
        last_o = next_o >= len_x;
      end
      SEL_GATHER: begin
        live   = cur_i < cnt_x;
        in_rng = (iv != '0) && (iv <= len_i);
        sel_o  = live && in_rng;
        err_o  = live && !in_rng;
        pos_o  = PTR_W'(iv - IDX_W'(1));
        last_o = next_o >= cnt_x;
      end
      default: begin
        sel_o  = (cur_i < len_x) && mask_i[slot];
        last_o = next_o >= len_x;
      end
    endcase
  end
endmodule

// File: rtl/vsel_pack.sv
module vsel_pack #(
  parameter int MAX_LEN = 8,
  parameter int IDX_W   = 4,
  parameter int PTR_W   = 3,
  parameter int ELEM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              sel_i,
  input  logic              err_i,
  input  logic              last_i,
  input  logic [ELEM_W-1:0] data_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [ELEM_W-1:0] wr_data_o,
  output logic              idx_err_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  res_len_o
);
  logic [IDX_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      idx_err_o <= 1'b0;
      done_o    <= 1'b0;
      res_len_o <= '0;
    end else begin
      wr_en_o   <= 1'b0;
      idx_err_o <= 1'b0;
      done_o    <= 1'b0;
      if (clear_i) begin
        count_q   <= '0;
        res_len_o <= '0;
      end else if (step_i) begin
        if (sel_i) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= count_q[PTR_W-1:0];
          wr_data_o <= data_i;
          count_q   <= count_q + IDX_W'(1);
        end
        idx_err_o <= err_i;
        if (last_i) begin
          done_o    <= 1'b1;
          res_len_o <= count_q + IDX_W'(sel_i);
        end
      end
    end
  end

  assert_contig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !done_o) |=> (!wr_en_o || wr_addr_o == $past(wr_addr_o) + PTR_W'(1)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_len_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> res_len_o <= IDX_W'(MAX_LEN));
  assert_len_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !done_o && !$past(done_o)) |=> $stable(res_len_o) || done_o);
endmodule

// File: rtl/vsel_unit.sv
module vsel_unit
  import vsel_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int ELEM_W  = 16,
  parameter int IDX_W   = $clog2(MAX_LEN + 1),
  parameter int PTR_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int CUR_W  = IDX_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [1:0]                mode_i,
  input  logic [IDX_W-1:0]          stride_i,
  input  logic [IDX_W-1:0]          src_len_i,
  input  logic [MAX_LEN*ELEM_W-1:0] src_i,
  input  logic [MAX_LEN*IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]          idx_cnt_i,
  input  logic [MAX_LEN-1:0]        mask_i,
  output logic                      busy_o,
  output logic                      wr_en_o,
  output logic [PTR_W-1:0]          wr_addr_o,
  output logic [ELEM_W-1:0]         wr_data_o,
  output logic                      idx_err_o,
  output logic                      done_o,
  output logic [IDX_W-1:0]          res_len_o
);
  localparam logic [IDX_W-1:0] LEN_MAX = IDX_W'(MAX_LEN);

  sel_mode_e              mode_q;
  logic                   busy_q;
  logic [CUR_W-1:0]       cur_q, cur_nxt;
  logic [IDX_W-1:0]       len_q, stride_q, cnt_q;
  logic [MAX_LEN*IDX_W-1:0] idx_q;
  logic [MAX_LEN-1:0]     mask_q;
  logic [ELEM_W-1:0]      src_q [MAX_LEN];
  logic                   accept, sel, err, last;
  logic [PTR_W-1:0]       pos;

  assign accept = start_i && !busy_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      mode_q   <= SEL_STRIDE;
      len_q    <= '0;
      stride_q <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      for (int i = 0; i < MAX_LEN; i++) src_q[i] <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      cur_q    <= '0;
      unique case (mode_i)
        2'b00:   mode_q <= SEL_STRIDE;
        2'b01:   mode_q <= SEL_GATHER;
        default: mode_q <= SEL_COMPRESS;
      endcase
      len_q    <= (src_len_i > LEN_MAX) ? LEN_MAX : src_len_i;
      cnt_q    <= (idx_cnt_i > LEN_MAX) ? LEN_MAX : idx_cnt_i;
      stride_q <= (stride_i == '0) ? IDX_W'(1) : stride_i;
      idx_q    <= idx_i;
      mask_q   <= mask_i;
      for (int i = 0; i < MAX_LEN; i++) src_q[i] <= src_i[i*ELEM_W +: ELEM_W];
    end else if (busy_q) begin
      cur_q <= cur_nxt;
      if (last) busy_q <= 1'b0;
    end
  end

  vsel_step #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .PTR_W(PTR_W)) i_step (
    .mode_i  (mode_q),
    .cur_i   (cur_q),
    .len_i   (len_q),
    .stride_i(stride_q),
    .cnt_i   (cnt_q),
    .idx_i   (idx_q),
    .mask_i  (mask_q),
    .sel_o   (sel),
    .err_o   (err),
    .last_o  (last),
    .pos_o   (pos),
    .next_o  (cur_nxt)
  );

  vsel_pack #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .PTR_W(PTR_W), .ELEM_W(ELEM_W)) i_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .step_i   (busy_q),
    .sel_i    (sel),
    .err_i    (err),
    .last_i   (last),
    .data_i   (src_q[pos]),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .idx_err_o(idx_err_o),
    .done_o   (done_o),
    .res_len_o(res_len_o)
  );

  assert_err_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_err_o |-> !wr_en_o);
  assert_err_gather_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_err_o |-> mode_q == SEL_GATHER);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(mode_q) && $stable(len_q) && $stable(cnt_q)));
endmodule

// File: tb/test_vsel_unit.sv
module test_vsel_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 8;
  localparam int ELEM_W  = 16;
  localparam int IDX_W   = 4;
  localparam int PTR_W   = 3;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  stride;
    logic [3:0]  len;
    logic [3:0]  cnt;
    logic [7:0]  mask;
    logic [31:0] idx;
    logic [3:0]  nexp;
    logic [3:0]  nerr;
    logic [31:0] pos;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 4'd4, 4'd8, 4'd0, 8'h00, 32'h0, 4'd2, 4'd0, 32'h51},
    '{2'd0, 4'd4, 4'd5, 4'd0, 8'h00, 32'h0, 4'd2, 4'd0, 32'h51},
    '{2'd0, 4'd4, 4'd4, 4'd0, 8'h00, 32'h0, 4'd1, 4'd0, 32'h1},
    '{2'd0, 4'd0, 4'd3, 4'd0, 8'h00, 32'h0, 4'd3, 4'd0, 32'h321},
    '{2'd0, 4'd3, 4'd7, 4'd0, 8'h00, 32'h0, 4'd3, 4'd0, 32'h741},
    '{2'd0, 4'd9, 4'd8, 4'd0, 8'h00, 32'h0, 4'd1, 4'd0, 32'h1},
    '{2'd1, 4'd0, 4'd8, 4'd4, 8'h00, 32'h7431, 4'd4, 4'd0, 32'h7431},
    '{2'd1, 4'd0, 4'd8, 4'd4, 8'h00, 32'h8902, 4'd2, 4'd2, 32'h82},
    '{2'd1, 4'd0, 4'd8, 4'd0, 8'h00, 32'h7431, 4'd0, 4'd0, 32'h0},
    '{2'd2, 4'd0, 4'd8, 4'd0, 8'h4D, 32'h0, 4'd4, 4'd0, 32'h7431},
    '{2'd2, 4'd0, 4'd8, 4'd0, 8'h00, 32'h0, 4'd0, 4'd0, 32'h0},
    '{2'd3, 4'd0, 4'd5, 4'd0, 8'hFF, 32'h0, 4'd5, 4'd0, 32'h54321}
  };

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [IDX_W-1:0] stride_i = '0, src_len_i = '0, idx_cnt_i = '0;
  logic [MAX_LEN*ELEM_W-1:0] src_i;
  logic [MAX_LEN*IDX_W-1:0] idx_i = '0;
  logic [MAX_LEN-1:0] mask_i = '0;
  logic busy_o, wr_en_o, idx_err_o, done_o;
  logic [PTR_W-1:0] wr_addr_o;
  logic [ELEM_W-1:0] wr_data_o;
  logic [IDX_W-1:0] res_len_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsel_unit #(.MAX_LEN(MAX_LEN), .ELEM_W(ELEM_W)) i_vsel_unit (
    .clk_i(clk), .rst_ni, .start_i, .mode_i, .stride_i, .src_len_i, .src_i,
    .idx_i, .idx_cnt_i, .mask_i, .busy_o, .wr_en_o, .wr_addr_o, .wr_data_o,
    .idx_err_o, .done_o, .res_len_o);

  function automatic logic [ELEM_W-1:0] src_val(int p);
    return 16'hC000 | ELEM_W'(p * 16'h0101);
  endfunction

  function automatic string req_of(vec_t v);
    if (v.mode == 2'd0) return (v.stride == 0) ? "R3" : "R2";
    if (v.mode == 2'd1) return (v.nerr != 0) ? "R5" : "R4";
    return "R6";
  endfunction

  function automatic int steps_of(vec_t v);
    int k, s;
    if (v.mode == 2'd0) begin
      k = (v.stride == 0) ? 1 : int'(v.stride);
      s = (int'(v.len) + k - 1) / k;
    end else if (v.mode == 2'd1) s = int'(v.cnt);
    else s = int'(v.len);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_job(input vec_t v, input int glitch_at);
    int wcount = 0, ecount = 0, cyc = 0, done_cyc = -1;
    string rq = req_of(v);
    @(negedge clk);
    mode_i = v.mode; stride_i = v.stride; src_len_i = v.len; idx_cnt_i = v.cnt;
    mask_i = v.mask; idx_i = v.idx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", int'(busy_o), 1);
    while (done_cyc < 0 && cyc < 40) begin
      if (cyc == glitch_at) begin
        mode_i = 2'b01; src_len_i = 4'd1; idx_cnt_i = 4'd1; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
      if (wr_en_o) begin
        chk(int'(wr_addr_o) == wcount, "R7", "packed address", int'(wr_addr_o), wcount);
        if (wcount < int'(v.nexp))
          chk(wr_data_o == src_val(int'(v.pos[wcount*4 +: 4])), rq, "element data",
              int'(wr_data_o), int'(src_val(int'(v.pos[wcount*4 +: 4]))));
        wcount++;
      end
      if (idx_err_o) ecount++;
      if (done_o) done_cyc = cyc;
    end
    chk(wcount == int'(v.nexp), rq, "element count", wcount, int'(v.nexp));
    chk(ecount == int'(v.nerr), "R5", "index error count", ecount, int'(v.nerr));
    chk(int'(res_len_o) == int'(v.nexp), "R8", "result length", int'(res_len_o), int'(v.nexp));
    chk(done_cyc == steps_of(v), "R9", "done latency", done_cyc, steps_of(v));
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done single cycle", int'(done_o), 0);
    chk(wr_en_o == 1'b0, "R7", "no write after done", int'(wr_en_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAX_LEN; i++) src_i[i*ELEM_W +: ELEM_W] = src_val(i + 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 1'b0 && wr_en_o == 1'b0, "R1", "idle under reset", int'({busy_o, wr_en_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0 && idx_err_o == 1'b0, "R1", "flags after reset", int'({done_o, idx_err_o}), 0);
    chk(res_len_o == '0, "R1", "length after reset", int'(res_len_o), 0);
    chk(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);

    for (int i = 0; i < NVEC; i++) run_job(VECS[i], -1);

    // R8: length held after done
    repeat (3) @(negedge clk);
    chk(int'(res_len_o) == 5, "R8", "length held", int'(res_len_o), 5);

    // R10: start while busy ignored; full compress of 8 elements
    run_job('{2'd2, 4'd0, 4'd8, 4'd0, 8'hFF, 32'h0, 4'd8, 4'd0, 32'h87654321}, 3);
    chk(busy_o == 1'b0, "R10", "idle after ignored start", int'(busy_o), 0);

    // R6: mask bits beyond length ignored
    run_job('{2'd2, 4'd0, 4'd2, 4'd0, 8'hFC, 32'h0, 4'd0, 4'd0, 32'h0}, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule